// File: doc/BRIEF.md
# Line RDI Auto-Insertion Controller

This block decides when the transmit side must send a line remote defect indication (RDI-L) back to the far end. Six receive-side defect flags come in on one vector, each with its own active-high inhibit bit. At every frame-start strobe the unmasked flags are ORed together. If any of them is active, the insert flag is raised. The overhead generator reads this flag when it sets the K2 bits.

Once raised, the flag is held for at least `HOLD_FRAMES` frames (20 by default). The hold is counted in frame-start strobes and restarts while any unmasked defect is still active. A single control input removes the minimum hold, and the flag then tracks the unmasked defects frame by frame. The flag changes only on the cycle after a frame-start strobe, so no frame is ever partly marked.

Top module: `rdi_line_ctrl`

## Requirements
- R1: If any unmasked defect is active on a cycle where `frame_start` is 1, `rdi_insert` is 1 on the next cycle. Defect bit positions: bit 0 loss of clock, bit 1 loss of signal, bit 2 out of frame, bit 3 loss of frame, bit 4 monitored line AIS, bit 5 signal fail.
- R2: A defect whose bit in `inhibit` is 1 has no effect on `rdi_insert`.
- R3: With `hold_off` at 0, `rdi_insert` stays 1 until the `HOLD_FRAMES`-th strobe after the last strobe that saw an unmasked defect. It falls on the cycle after that strobe, so a single-strobe defect keeps the flag up for exactly `HOLD_FRAMES` frames.
- R4: While an unmasked defect stays active across strobes, `rdi_insert` stays 1 and the hold restarts at every strobe.
- R5: With `hold_off` at 1, `rdi_insert` after each strobe equals the OR of the unmasked defects seen at that strobe.
- R6: `rdi_insert` changes value only on the cycle after a cycle where `frame_start` is 1.
- R7: After reset `rdi_insert` is 0 and the hold counter is empty. With `inhibit` at 0, every source contributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| defects | input | 6 | Receive defect flags, bit order as in R1 |
| inhibit | input | 6 | Per-source inhibit, 1 masks that source |
| hold_off | input | 1 | 1 removes the minimum hold |
| rdi_insert | output | 1 | RDI-L insert request to the overhead generator |

## Verification
A wrong hold count appears at the ports as a release at the wrong strobe. It is visible on the cycle after the strobe where the flag should have fallen or stayed, and at most `HOLD_FRAMES` strobes after the defect clears. A wrong mask decode shows up on the cycle after the first strobe that sees the affected source. A flag that moves between strobes is caught on the very cycle it moves.

// File: rtl/rdi_line_ctrl.sv
module rdi_line_ctrl #(
  parameter int HOLD_FRAMES = 20,
  parameter int NSRC        = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic [NSRC-1:0] defects,
  input  logic [NSRC-1:0] inhibit,
  input  logic            hold_off,
  output logic            rdi_insert
);
  localparam int CW = $clog2(HOLD_FRAMES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(HOLD_FRAMES - 1);

  logic [CW-1:0] cnt;
  logic          active;

  assign active = |(defects & ~inhibit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      rdi_insert <= 1'b0;
    end else if (frame_start) begin
      if (active) begin
        cnt        <= hold_off ? '0 : RELOAD;
        rdi_insert <= 1'b1;
      end else if (hold_off || cnt == '0) begin
        cnt        <= '0;
        rdi_insert <= 1'b0;
      end else begin
        cnt        <= cnt - 1'b1;
      end
    end
  end

  AST_SET_ON_DEFECT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && active |=> rdi_insert); // R1
  AST_HOLD_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !active && !hold_off && cnt != '0 |=> rdi_insert); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= RELOAD); // R3
  AST_DIRECT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && hold_off |=> rdi_insert == $past(active)); // R5
  AST_FRAME_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(rdi_insert)); // R6
endmodule

// File: tb/rdi_line_ctrl_tb_top.sv
module rdi_line_ctrl_tb_top;
  localparam int HOLD = 20;
  logic clk = 1'b0, rst_n = 1'b0, fs = 1'b0, hoff = 1'b0;
  logic [5:0] dft = '0, msk = '0;
  logic rdi;
  int checks = 0, errors = 0;
  bit done = 0;
  bit exp_rdi = 0;
  int exp_cnt = 0;
  string tag = "R7";

  always #5 clk = ~clk;

  rdi_line_ctrl #(.HOLD_FRAMES(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(fs), .defects(dft),
    .inhibit(msk), .hold_off(hoff), .rdi_insert(rdi));

  function automatic bit unmasked(input logic [5:0] d, input logic [5:0] m);
    return |(d & ~m);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_rdi <= 0; exp_cnt <= 0; tag <= "R7";
    end else if (!fs) begin
      tag <= "R6";
    end else if (unmasked(dft, msk)) begin
      exp_rdi <= 1; exp_cnt <= hoff ? 0 : HOLD - 1; tag <= exp_rdi ? "R4" : "R1";
    end else if (hoff) begin
      exp_rdi <= 0; exp_cnt <= 0; tag <= "R5";
    end else if (exp_cnt == 0) begin
      exp_rdi <= 0; tag <= "R3";
    end else begin
      exp_cnt <= exp_cnt - 1; tag <= "R3";
    end
  end

  task automatic check(input string req, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s rdi_insert actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; fs = 0; dft = '0; msk = '0; hoff = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  task automatic strobe();
    fs = 1; @(negedge clk); fs = 0; @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog expired actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk); @(negedge clk);
    check("R7", rdi, 1'b0);
    rst_n = 1; @(negedge clk);
    check("R7", rdi, 1'b0);

    for (int i = 0; i < 6; i++) begin
      do_reset();
      dft = 6'(1 << i); msk = 6'(1 << i); strobe();
      check("R2", rdi, 1'b0);
      msk = '0; fs = 1; @(negedge clk); fs = 0;
      check("R1", rdi, 1'b1);
      @(negedge clk);
    end

    do_reset();
    dft = 6'b000010; strobe(); dft = '0;
    check("R1", rdi, 1'b1);
    for (int k = 1; k < HOLD; k++) begin
      repeat (3) @(negedge clk);
      check("R6", rdi, 1'b1);
      strobe();
      check("R3", rdi, 1'b1);
    end
    strobe();
    check("R3", rdi, 1'b0);

    do_reset();
    dft = 6'b100000;
    for (int k = 0; k < HOLD + 5; k++) strobe();
    check("R4", rdi, 1'b1);
    dft = '0;
    for (int k = 0; k < HOLD - 1; k++) strobe();
    check("R4", rdi, 1'b1);
    strobe();
    check("R3", rdi, 1'b0);

    do_reset();
    hoff = 1; dft = 6'b001000; strobe();
    check("R5", rdi, 1'b1);
    dft = '0; strobe();
    check("R5", rdi, 1'b0);
    hoff = 0; dft = 6'b010000; strobe(); dft = '0; hoff = 1; strobe();
    check("R5", rdi, 1'b0);

    do_reset();
    for (int n = 0; n < 6000; n++) begin
      check(tag, rdi, exp_rdi);
      fs = ($urandom % 5) == 0;
      if ($urandom % 30 == 0) dft = ($urandom % 3 == 0) ? 6'($urandom) : 6'd0;
      if ($urandom % 150 == 0) msk = ($urandom % 2 == 0) ? 6'($urandom) : 6'd0;
      if ($urandom % 400 == 0) hoff = 1'($urandom);
      @(negedge clk);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule